// File: doc/BRIEF.md
# Single-Precision Result Packer

This block takes a floating-point result held in an unpacked working form and turns it into a 32-bit IEEE-754 single-precision word. The working form has a class code, a sign, a signed unbiased exponent, a wide mantissa with the hidden one at its top bit, and a sticky bit that stands for any nonzero bits already dropped below the mantissa. It is the last stage of an arithmetic pipe. The block rounds the value to 24 significant bits, picks the normal or subnormal encoding, and handles overflow. It reports overflow, underflow and inexact conditions beside the packed word.

Rounding uses guard, round and sticky bits. One of four directions applies, picked per operation. When a value is too small for the normal range, the block shifts it further right before rounding. Rounding can then carry it back up to the smallest normal number. When a value is too large, the block saturates it to infinity or to the largest finite magnitude, as the rounding direction and the sign decide. An underflow-enable input forces underflow to be reported for every subnormal result, exact ones included. All outputs are registered, one cycle after a valid input.

Top module: `sp_result_packer`

## Requirements
- R1: While reset is asserted, and after it until the first valid input, `out_valid`, `out_word` and all three flags are zero.
- R2: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. Without a valid input, `out_word` and the flags keep their previous values.
- R3: A NaN input (class code 3) packs as the sign, exponent field 255, and a fraction equal to mantissa bits MANT_W-2 down to MANT_W-24, with fraction bit 22 (the quiet bit) forced to 1. No flag is raised.
- R4: Infinity (class 2) packs as the sign, exponent field 255 and fraction 0. Zero (class 0) packs as the sign bit with all other bits clear. Neither raises a flag.
- R5: A number (class 1) must have mantissa bit MANT_W-1 set. Its biased exponent is the input exponent plus 127, and its 24 kept bits are mantissa bits MANT_W-1 down to MANT_W-24. Rounding-mode code 0 is nearest with ties to even, 1 is toward zero, 2 is toward +infinity and 3 is toward -infinity. `out_inexact` is set when any discarded bit or the sticky input is nonzero.
- R6: On the normal path, when rounding carries the significand up to 2.0, the exponent field goes up by one and the fraction field is zero.
- R7: A biased exponent of 0 or below selects the subnormal path. The value is shifted right by a further (1 - biased exponent) places before rounding, and the exponent field is 0.
- R8: When subnormal rounding carries into the hidden position, the result is the smallest normal: exponent field 1, fraction 0. No underflow is raised.
- R9: A result that stays subnormal raises `out_underflow` when it was inexact or when `in_uf_en` is high. No other result raises it.
- R10: A final biased exponent of 255 or more is an overflow. The result is infinity in mode 0, never in mode 1, in mode 2 only for a positive sign, and in mode 3 only for a negative sign. Otherwise the result is the largest finite magnitude (exponent field 254, fraction all ones). `out_inexact` is set in both cases.
- R11: `out_overflow` is raised exactly when an overflow packs to infinity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operand is present this cycle |
| in_class | input | 2 | 0 zero, 1 number, 2 infinity, 3 NaN |
| in_sign | input | 1 | Sign of the value |
| in_exp | input | EXP_W | Signed unbiased exponent |
| in_mant | input | MANT_W | Mantissa, hidden one at bit MANT_W-1 |
| in_sticky | input | 1 | Nonzero bits were lost below the mantissa |
| in_rmode | input | 2 | Rounding direction code |
| in_uf_en | input | 1 | Report underflow for every subnormal result |
| out_valid | output | 1 | Result registered from the previous cycle |
| out_word | output | 32 | Packed single-precision word |
| out_overflow | output | 1 | Overflow to infinity |
| out_underflow | output | 1 | Subnormal result, inexact or enabled |
| out_inexact | output | 1 | Result differs from the input value |

## Verification
The bench aims at the edges of the rounding step. It drives exact ties with an even and an odd last bit, where a design that ignored the kept bit would round a tie away from even. It drives significands of all ones, which carry to 2.0 or, on the subnormal path, to the smallest normal. A design that mishandled these would give a doubled fraction, a wrong exponent, or a false underflow. It drives exponents just below and far below the normal range, where a wrong shift count or a lost sticky bit would give a wrong fraction or miss inexactness. It drives overflows under every mode and sign, where a swapped direction would saturate to the wrong value or raise overflow for a finite result.

// File: rtl/sprp_pkg.sv
package sprp_pkg;

  localparam int FRAC_W    = 23;
  localparam int SIG_W     = FRAC_W + 1;
  localparam int EXP_BIAS  = 127;
  localparam int EXP_FULL  = 255;

  typedef enum logic [1:0] {
    CL_ZERO = 2'd0,
    CL_NUM  = 2'd1,
    CL_INF  = 2'd2,
    CL_NAN  = 2'd3
  } val_class_e;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_UP   = 2'd2,
    RM_DOWN = 2'd3
  } rnd_mode_e;

  // Decide whether to add one unit in the last kept place.
  function automatic logic rnd_up(rnd_mode_e mode, logic sign, logic lsb,
                                  logic g, logic rs);
    logic lost;
    lost = g | rs;
    case (mode)
      RM_NEAR: return g & (rs | lsb);
      RM_ZERO: return 1'b0;
      RM_UP:   return ~sign & lost;
      default: return sign & lost;
    endcase
  endfunction

  // On overflow: saturate to infinity (1) or to the largest finite value (0).
  function automatic logic ovf_to_inf(rnd_mode_e mode, logic sign);
    case (mode)
      RM_NEAR: return 1'b1;
      RM_ZERO: return 1'b0;
      RM_UP:   return ~sign;
      default: return sign;
    endcase
  endfunction

endpackage

// File: rtl/sprp_align.sv
module sprp_align #(
  parameter int EXP_W  = 10,
  parameter int MANT_W = 32
) (
  input  logic [EXP_W-1:0]            in_exp,
  input  logic [MANT_W-1:0]           in_mant,
  input  logic                        in_sticky,
  output logic signed [EXP_W+1:0]     biased,
  output logic                        sub_path,
  output logic [sprp_pkg::SIG_W-1:0]  keep,
  output logic                        guard_b,
  output logic                        round_b,
  output logic                        sticky_b
);
  localparam int BE_W  = EXP_W + 2;
  localparam int SH_W  = $clog2(MANT_W + 1);
  localparam int LOW_W = MANT_W - sprp_pkg::SIG_W - 2;
  localparam logic signed [BE_W-1:0] SHIFT_LIM = BE_W'(MANT_W);
  localparam logic signed [BE_W-1:0] ONE       = BE_W'(1);

  logic signed [BE_W-1:0] need;
  logic [SH_W-1:0]        sh;
  logic [2*MANT_W-1:0]    wide;
  logic [MANT_W-1:0]      hi;
  logic                   lost_lo;

  assign biased   = {{2{in_exp[EXP_W-1]}}, in_exp} + BE_W'(sprp_pkg::EXP_BIAS);
  assign sub_path = (biased <= 0);
  assign need     = ONE - biased;

  always_comb begin
    if (!sub_path)              sh = '0;
    else if (need > SHIFT_LIM)  sh = SH_W'(MANT_W);
    else                        sh = need[SH_W-1:0];
  end

  assign wide    = {in_mant, {MANT_W{1'b0}}} >> sh;
  assign hi      = wide[2*MANT_W-1:MANT_W];
  assign lost_lo = |wide[MANT_W-1:0];

  assign keep     = hi[MANT_W-1 -: sprp_pkg::SIG_W];
  assign guard_b  = hi[LOW_W+1];
  assign round_b  = hi[LOW_W];
  assign sticky_b = (|hi[LOW_W-1:0]) | lost_lo | in_sticky;
endmodule

// File: rtl/sprp_round.sv
module sprp_round (
  input  logic [sprp_pkg::SIG_W-1:0] keep,
  input  logic                       guard_b,
  input  logic                       round_b,
  input  logic                       sticky_b,
  input  logic                       sign,
  input  sprp_pkg::rnd_mode_e        mode,
  output logic [sprp_pkg::SIG_W:0]   sum,
  output logic                       inexact
);
  logic up;

  assign inexact = guard_b | round_b | sticky_b;
  assign up      = sprp_pkg::rnd_up(mode, sign, keep[0], guard_b, round_b | sticky_b);
  assign sum     = {1'b0, keep} + {{sprp_pkg::SIG_W{1'b0}}, up};
endmodule

// File: rtl/sprp_assemble.sv
module sprp_assemble #(
  parameter int BE_W = 12
) (
  input  sprp_pkg::val_class_e          cls,
  input  logic                          sign,
  input  logic [sprp_pkg::FRAC_W-1:0]   nan_bits,
  input  logic                          sub_path,
  input  logic signed [BE_W-1:0]        biased,
  input  logic [sprp_pkg::SIG_W:0]      sum,
  input  logic                          inexact,
  input  sprp_pkg::rnd_mode_e           mode,
  input  logic                          uf_en,
  output logic [31:0]                   word,
  output logic                          ovf,
  output logic                          unf,
  output logic                          inx,
  output logic                          ev_promote,
  output logic                          ev_exp_carry,
  output logic                          ev_overflow,
  output logic                          ev_to_inf
);
  import sprp_pkg::*;

  localparam logic signed [BE_W-1:0] EXP_TOP = BE_W'(EXP_FULL);
  localparam logic [FRAC_W-1:0] QUIET_BIT = {1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic [FRAC_W-1:0] FRAC_ONES = '1;

  logic signed [BE_W-1:0] e_fin;
  logic                   is_num;
  logic                   big;
  logic                   inf_sel;

  assign e_fin   = biased + {{(BE_W-1){1'b0}}, sum[SIG_W]};
  assign is_num  = (cls == CL_NUM);
  assign big     = (e_fin >= EXP_TOP);
  assign inf_sel = ovf_to_inf(mode, sign);

  assign ev_promote   = is_num &  sub_path & sum[SIG_W-1];
  assign ev_exp_carry = is_num & ~sub_path & sum[SIG_W];
  assign ev_overflow  = is_num & ~sub_path & big;
  assign ev_to_inf    = ev_overflow & inf_sel;

  always_comb begin
    word = '0;
    ovf  = 1'b0;
    unf  = 1'b0;
    inx  = 1'b0;
    case (cls)
      CL_ZERO: word = {sign, 31'b0};
      CL_INF:  word = {sign, 8'hFF, {FRAC_W{1'b0}}};
      CL_NAN:  word = {sign, 8'hFF, nan_bits | QUIET_BIT};
      default: begin
        inx = inexact;
        if (sub_path) begin
          // Bit 23 of the sum lands in the exponent field: a carry there
          // yields the smallest normal number on its own.
          word = {sign, 7'b0, sum[SIG_W-1], sum[FRAC_W-1:0]};
          unf  = ~sum[SIG_W-1] & (inexact | uf_en);
        end else if (big) begin
          inx = 1'b1;
          ovf = inf_sel;
          if (inf_sel) word = {sign, 8'hFF, {FRAC_W{1'b0}}};
          else         word = {sign, 8'hFE, FRAC_ONES};
        end else begin
          word = {sign, e_fin[7:0], sum[FRAC_W-1:0]};
        end
      end
    endcase
  end
endmodule

// File: rtl/sp_result_packer.sv
module sp_result_packer #(
  parameter int EXP_W  = 10,
  parameter int MANT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        in_class,
  input  logic              in_sign,
  input  logic [EXP_W-1:0]  in_exp,
  input  logic [MANT_W-1:0] in_mant,
  input  logic              in_sticky,
  input  logic [1:0]        in_rmode,
  input  logic              in_uf_en,
  output logic              out_valid,
  output logic [31:0]       out_word,
  output logic              out_overflow,
  output logic              out_underflow,
  output logic              out_inexact
);
  import sprp_pkg::*;

  localparam int BE_W = EXP_W + 2;

  logic signed [BE_W-1:0] biased;
  logic                   sub_path;
  logic [SIG_W-1:0]       keep;
  logic                   guard_b, round_b, sticky_b;
  logic [SIG_W:0]         sum;
  logic                   rnd_inexact;
  logic [31:0]            word_c;
  logic                   ovf_c, unf_c, inx_c;
  logic                   ev_promote, ev_exp_carry, ev_overflow, ev_to_inf;
  rnd_mode_e              mode;
  val_class_e             cls;

  assign mode = rnd_mode_e'(in_rmode);
  assign cls  = val_class_e'(in_class);

  sprp_align #(.EXP_W(EXP_W), .MANT_W(MANT_W)) u_align (
    .in_exp   (in_exp),
    .in_mant  (in_mant),
    .in_sticky(in_sticky),
    .biased   (biased),
    .sub_path (sub_path),
    .keep     (keep),
    .guard_b  (guard_b),
    .round_b  (round_b),
    .sticky_b (sticky_b)
  );

  sprp_round u_round (
    .keep    (keep),
    .guard_b (guard_b),
    .round_b (round_b),
    .sticky_b(sticky_b),
    .sign    (in_sign),
    .mode    (mode),
    .sum     (sum),
    .inexact (rnd_inexact)
  );

  sprp_assemble #(.BE_W(BE_W)) u_asm (
    .cls         (cls),
    .sign        (in_sign),
    .nan_bits    (in_mant[MANT_W-2 -: FRAC_W]),
    .sub_path    (sub_path),
    .biased      (biased),
    .sum         (sum),
    .inexact     (rnd_inexact),
    .mode        (mode),
    .uf_en       (in_uf_en),
    .word        (word_c),
    .ovf         (ovf_c),
    .unf         (unf_c),
    .inx         (inx_c),
    .ev_promote  (ev_promote),
    .ev_exp_carry(ev_exp_carry),
    .ev_overflow (ev_overflow),
    .ev_to_inf   (ev_to_inf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_word      <= '0;
      out_overflow  <= 1'b0;
      out_underflow <= 1'b0;
      out_inexact   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_word      <= word_c;
        out_overflow  <= ovf_c;
        out_underflow <= unf_c;
        out_inexact   <= inx_c;
      end
    end
  end
endmodule

// File: rtl/sp_result_packer_chk.sv
module sp_result_packer_chk #(
  parameter int MANT_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [1:0]        in_class,
  input logic              in_mant_top,
  input logic [1:0]        in_rmode,
  input logic              out_valid,
  input logic [31:0]       out_word,
  input logic              out_overflow,
  input logic              out_underflow,
  input logic              out_inexact,
  input logic              ev_promote,
  input logic              ev_exp_carry,
  input logic              ev_overflow,
  input logic              ev_to_inf
);
  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_word)));

  p_hidden_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_class == 2'd1) |-> in_mant_top);

  p_inf_exact_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_class == 2'd2) |=> (out_word[30:0] == 31'h7F80_0000 && !out_inexact));

  p_carry_frac_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ev_exp_carry && !ev_overflow) |=> (out_word[22:0] == 23'd0));

  p_promote_min_normal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ev_promote) |=> (out_word[30:0] == 31'h0080_0000 && !out_underflow));

  p_unf_subnormal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_underflow |-> (out_word[30:23] == 8'd0));

  p_no_overflow_rz_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ev_overflow && in_rmode == 2'd1) |=>
      (!out_overflow && out_word[30:0] == 31'h7F7F_FFFF && out_inexact));

  p_inf_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ev_to_inf) |=> out_overflow);

  p_ovf_is_inf_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_overflow |-> (out_word[30:0] == 31'h7F80_0000));
endmodule

bind sp_result_packer sp_result_packer_chk #(.MANT_W(MANT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_class     (in_class),
  .in_mant_top  (in_mant[MANT_W-1]),
  .in_rmode     (in_rmode),
  .out_valid    (out_valid),
  .out_word     (out_word),
  .out_overflow (out_overflow),
  .out_underflow(out_underflow),
  .out_inexact  (out_inexact),
  .ev_promote   (ev_promote),
  .ev_exp_carry (ev_exp_carry),
  .ev_overflow  (ev_overflow),
  .ev_to_inf    (ev_to_inf)
);

// File: tb/sim_sp_result_packer.sv
`timescale 1ns/1ps
module sim_sp_result_packer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  in_class = 2'd0;
  logic        in_sign = 1'b0;
  logic [9:0]  in_exp = '0;
  logic [31:0] in_mant = '0;
  logic        in_sticky = 1'b0;
  logic [1:0]  in_rmode = 2'd0;
  logic        in_uf_en = 1'b0;
  logic        out_valid;
  logic [31:0] out_word;
  logic        out_overflow, out_underflow, out_inexact;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [31:0] q_word[$];
  logic [2:0]  q_flag[$];
  string       q_tagw[$];
  string       q_tagf[$];

  always #2 clk = ~clk;

  sp_result_packer u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
    .in_sign(in_sign), .in_exp(in_exp), .in_mant(in_mant), .in_sticky(in_sticky),
    .in_rmode(in_rmode), .in_uf_en(in_uf_en), .out_valid(out_valid),
    .out_word(out_word), .out_overflow(out_overflow),
    .out_underflow(out_underflow), .out_inexact(out_inexact)
  );

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural model: scale the value to an integer count of result ulps,
  // compare the remainder against one half, then form the word arithmetically.
  task automatic model(input int cls, input bit s, input int e, input longint m,
                       input bit st, input int mode, input bit ue);
    longint mag, big_i, rem, half;
    int be, q, d;
    bit any, above, tie, up, ovf, unf, inx, toinf;
    string tw, tf;
    ovf = 0; unf = 0; inx = 0;
    if (cls == 0) begin mag = 0; tw = "R4"; tf = "R4"; end
    else if (cls == 2) begin mag = 64'h7F80_0000; tw = "R4"; tf = "R4"; end
    else if (cls == 3) begin
      mag = 64'h7F80_0000 | ((m >> 8) & 64'h7F_FFFF) | 64'h40_0000;
      tw = "R3"; tf = "R3";
    end else begin
      be = e + 127;
      q = ((be > 0) ? be : 1) - 150;
      d = 31 + q - e;
      if (d > 40) d = 40;
      big_i = m >> d;
      rem = m - (big_i << d);
      half = 64'sd1 << (d - 1);
      any = (rem != 0) || st;
      above = (rem > half) || (rem == half && st);
      tie = (rem == half) && !st;
      case (mode)
        0: up = above || (tie && big_i[0]);
        1: up = 0;
        2: up = !s && any;
        default: up = s && any;
      endcase
      big_i = big_i + longint'(up);
      inx = any;
      if (be > 0) begin
        mag = (longint'(be - 1) << 23) + big_i;
        tw = (big_i == (64'sd1 << 24)) ? "R6" : "R5";
        tf = "R5";
        if ((mag >> 23) >= 255) begin
          toinf = (mode == 0) || (mode == 2 && !s) || (mode == 3 && s);
          mag = toinf ? 64'h7F80_0000 : 64'h7F7F_FFFF;
          ovf = toinf; inx = 1;
          tw = "R10"; tf = "R11";
        end
      end else begin
        mag = big_i;
        unf = (big_i < (64'sd1 << 23)) && (any || ue);
        tw = (big_i == (64'sd1 << 23)) ? "R8" : "R7";
        tf = "R9";
      end
    end
    q_word.push_back({s, mag[30:0]});
    q_flag.push_back({ovf, unf, inx});
    q_tagw.push_back(tw);
    q_tagf.push_back(tf);
  endtask

  task automatic compare_outputs();
    logic [31:0] ew;
    logic [2:0]  ef;
    string tw, tf;
    if (q_word.size() > 0) begin
      ew = q_word.pop_front(); ef = q_flag.pop_front();
      tw = q_tagw.pop_front(); tf = q_tagf.pop_front();
      check(out_valid === 1'b1, "R2 valid after input", longint'(out_valid), 1);
      check(out_word === ew, {tw, " word"}, longint'(out_word), longint'(ew));
      check({out_overflow, out_underflow, out_inexact} === ef, {tf, " flags"},
            longint'({out_overflow, out_underflow, out_inexact}), longint'(ef));
    end else begin
      check(out_valid === 1'b0, "R2 idle valid", longint'(out_valid), 0);
    end
  endtask

  task automatic send(input int cls, input bit s, input int e, input logic [31:0] m,
                      input bit st, input int mode, input bit ue);
    @(negedge clk);
    compare_outputs();
    in_valid = 1'b1; in_class = cls[1:0]; in_sign = s; in_exp = e[9:0];
    in_mant = m; in_sticky = st; in_rmode = mode[1:0]; in_uf_en = ue;
    model(cls, s, e, longint'(m), st, mode, ue);
  endtask

  task automatic idle();
    logic [31:0] hold_w;
    @(negedge clk);
    compare_outputs();
    hold_w = out_word;
    in_valid = 1'b0; in_class = 2'd1; in_mant = 32'h1234_5678; in_exp = 10'd3;
    @(negedge clk);
    compare_outputs();
    check(out_word === hold_w, "R2 word held while idle", longint'(out_word), longint'(hold_w));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0 && out_word === 32'd0, "R1 reset outputs",
          longint'({out_valid, out_word}), 0);
    check({out_overflow, out_underflow, out_inexact} === 3'b000, "R1 reset flags",
          longint'({out_overflow, out_underflow, out_inexact}), 0);
    rst_n = 1'b1;
    // R3 / R4 specials
    send(0, 1, 5, 32'h8000_0000, 1, 0, 1);
    send(2, 0, 0, 32'h8000_0000, 0, 1, 0);
    send(3, 1, 0, 32'h8123_4500, 0, 0, 0);
    send(3, 0, 0, 32'hC000_0000, 0, 0, 0);
    // R5 normal rounding
    send(1, 0, 0, 32'h8000_0000, 0, 0, 0);
    send(1, 0, 0, 32'h8000_0080, 0, 0, 0);
    send(1, 0, 0, 32'h8000_0180, 0, 0, 0);
    send(1, 0, 0, 32'h8000_0080, 1, 0, 0);
    send(1, 0, 3, 32'h8000_0001, 0, 2, 0);
    send(1, 1, 3, 32'h8000_0001, 0, 2, 0);
    send(1, 1, 3, 32'h8000_0001, 0, 3, 0);
    send(1, 1, 3, 32'h8000_00FF, 0, 1, 0);
    idle();
    // R6 carry to 2.0
    send(1, 0, 0, 32'hFFFF_FF80, 0, 0, 0);
    send(1, 1, -20, 32'hFFFF_FF01, 0, 3, 0);
    // R7 / R9 subnormal
    send(1, 0, -127, 32'h8000_0000, 0, 0, 0);
    send(1, 0, -127, 32'h8000_0000, 0, 0, 1);
    send(1, 0, -150, 32'h8000_0000, 0, 0, 0);
    send(1, 1, -140, 32'hA5A5_A5A5, 0, 1, 0);
    send(1, 0, -400, 32'h8000_0000, 0, 2, 0);
    send(1, 1, -400, 32'h8000_0000, 0, 2, 1);
    // R8 promotion
    send(1, 0, -127, 32'hFFFF_FFFF, 0, 0, 1);
    send(1, 1, -127, 32'hFFFF_FE00, 1, 3, 0);
    // R10 / R11 overflow
    send(1, 0, 127, 32'hFFFF_FFFF, 0, 0, 0);
    send(1, 0, 127, 32'hFFFF_FFFF, 0, 1, 0);
    send(1, 0, 128, 32'h8000_0000, 0, 2, 0);
    send(1, 1, 128, 32'h8000_0000, 0, 2, 0);
    send(1, 1, 128, 32'h8000_0000, 0, 3, 0);
    send(1, 0, 300, 32'h8000_0000, 0, 3, 0);
    idle();
    for (int i = 0; i < 400; i++) begin
      int cls;
      cls = ($urandom_range(0, 15) == 0) ? int'($urandom_range(0, 3)) : 1;
      if (cls == 1 && $urandom_range(0, 7) == 0) begin
        @(negedge clk); compare_outputs(); in_valid = 1'b0;
      end
      send(cls, 1'($urandom), int'($urandom_range(0, 300)) - 165,
           32'h8000_0000 | $urandom, 1'($urandom), int'($urandom_range(0, 3)),
           1'($urandom));
    end
    idle();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule